// File: doc/BRIEF.md
# Shadow-Stack-Aware Protection Entry Permission Check

This block decides whether one memory access is permitted by one physical memory protection entry. It assumes that address matching and priority among entries have already chosen this entry. It has no clock and no state. The inputs are the kind of access, the effective privilege level, an execute-as-read qualifier, a shadow-stack qualifier, the entry's read/write/execute/lock bits and its extended-attribute bit. Two enables turn on machine and user shadow stacks. The single output is the permit verdict.

When the extended-attribute bit is clear, the entry follows the ordinary rules. When it is set, two permission encodings become shadow-stack regions, one for machine level and one for user level. A shadow-stack region has its own access rules. Every other encoding with the bit set denies all accesses. A build parameter states whether user-level shadow stacks exist. Without them, user shadow-stack accesses are judged by the ordinary rules.

Top module: `pmp_entry_perm_check`

## Requirements
- R1: A shadow-stack access at machine level (priv code 3) is permitted only when the entry is a machine shadow-stack region: extended bit 1, x=0 w=1 r=0, and machine shadow-stack enable 1.
- R2: With user support built in, a shadow-stack access at user level (priv code 0) is permitted only when the entry is a user shadow-stack region: extended bit 1, x=1 w=1 r=0, and user shadow-stack enable 1.
- R3: A non-shadow-stack access to a machine shadow-stack region is permitted only when it is a machine-level load (kind code 0) with execute-as-read clear.
- R4: A non-shadow-stack access to a user shadow-stack region is permitted only when it is a user-level load with execute-as-read clear.
- R5: An entry whose extended bit is 1 but which is no shadow-stack region denies every access.
- R6: Under the ordinary rules, a load needs r, and also x when execute-as-read is set. A store (kind code 1) needs w. A fetch (kind code 2) needs x. These rules cover privilege codes 0, 1 and 2, and a locked entry at machine level.
- R7: With the extended bit clear, a non-shadow-stack machine-level access to an unlocked entry is permitted whatever r, w and x hold.
- R8: A shadow-stack access at privilege codes 1 or 2 falls through to the later rules. So does a shadow-stack access at user level when user support is not built in.
- R9: When user support is not built in, no entry is a user shadow-stack region. An entry with extended bit 1 and x=1 w=1 r=0 then denies every access.
- R10: Access kind code 3 is reserved and is never permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| priv_lvl | input | 2 | Effective privilege: 3 machine, 0 user, 1 and 2 supervisor-like |
| exec_as_read | input | 1 | Load that also requires execute permission |
| ss_access | input | 1 | Access is a shadow-stack access |
| perm_r | input | 1 | Entry read bit |
| perm_w | input | 1 | Entry write bit |
| perm_x | input | 1 | Entry execute bit |
| perm_lock | input | 1 | Entry lock bit |
| ext_attr | input | 1 | Entry extended-attribute bit |
| m_ss_en | input | 1 | Machine shadow-stack enable |
| u_ss_en | input | 1 | User shadow-stack enable |
| permit | output | 1 | Access is permitted |

## Verification
The bench builds two copies of the block. `dut` has user shadow-stack support built in, which reaches the user region rules in R2 and R4. `dut_nu` has it left out, which reaches the fall-through in R8 and the deny in R9. Both copies are driven with a table of hand-derived corner vectors. The bench then sweeps every combination of the eleven inputs and compares each copy against a reference model written as a separate decision ladder.

// File: rtl/pmp_perm_pkg.sv
package pmp_perm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] PRIV_USER    = 2'd0;
  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  // permission triple in x,w,r order
  localparam logic [2:0] XWR_M_SS = 3'b010;
  localparam logic [2:0] XWR_U_SS = 3'b110;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic fn_ordinary_ok(input logic [1:0] kind, input perm_t p,
                                          input logic xr);
    logic ok;
    case (kind)
      ACC_LOAD:  ok = p.r & (p.x | ~xr);
      ACC_STORE: ok = p.w;
      ACC_FETCH: ok = p.x;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic fn_region_load_ok(input logic [1:0] kind, input logic lvl_ok,
                                             input logic xr);
    return lvl_ok & (kind == ACC_LOAD) & ~xr;
  endfunction

endpackage

// File: rtl/pmp_ss_region_classify.sv
module pmp_ss_region_classify
  import pmp_perm_pkg::*;
#(
  parameter bit USER_SS_IMPL = 1'b1
) (
  input  logic  ext_attr,
  input  perm_t perm,
  input  logic  m_ss_en,
  input  logic  u_ss_en,
  output logic  is_mregion,
  output logic  is_uregion,
  output logic  ext_invalid
);
  logic [2:0] xwr;
  assign xwr = {perm.x, perm.w, perm.r};

  assign is_mregion = ext_attr & m_ss_en & (xwr == XWR_M_SS);

  generate
    if (USER_SS_IMPL) begin : g_user_ss
      assign is_uregion = ext_attr & u_ss_en & (xwr == XWR_U_SS);
    end else begin : g_no_user_ss
      logic unused_u;
      assign unused_u   = u_ss_en;
      assign is_uregion = 1'b0;
    end
  endgenerate

  assign ext_invalid = ext_attr & ~is_mregion & ~is_uregion;
endmodule

// File: rtl/pmp_ss_rule.sv
module pmp_ss_rule
  import pmp_perm_pkg::*;
#(
  parameter bit USER_SS_IMPL = 1'b1
) (
  input  logic       ss_access,
  input  logic       lvl_m,
  input  logic       lvl_u,
  input  logic [1:0] acc_kind,
  input  logic       exec_as_read,
  input  logic       is_mregion,
  input  logic       is_uregion,
  output logic       ss_decided,
  output logic       ss_ok
);
  logic ss_m_path, ss_u_path;
  assign ss_m_path = ss_access & lvl_m;

  generate
    if (USER_SS_IMPL) begin : g_u_path
      assign ss_u_path = ss_access & lvl_u;
    end else begin : g_no_u_path
      assign ss_u_path = 1'b0;
    end
  endgenerate

  always_comb begin
    ss_decided = 1'b1;
    ss_ok      = 1'b0;
    if (ss_m_path)       ss_ok = is_mregion;
    else if (ss_u_path)  ss_ok = is_uregion;
    else if (is_mregion) ss_ok = fn_region_load_ok(acc_kind, lvl_m, exec_as_read);
    else if (is_uregion) ss_ok = fn_region_load_ok(acc_kind, lvl_u, exec_as_read);
    else                 ss_decided = 1'b0;
  end
endmodule

// File: rtl/pmp_ordinary_rule.sv
module pmp_ordinary_rule
  import pmp_perm_pkg::*;
(
  input  logic       lvl_m,
  input  logic       lock,
  input  logic [1:0] acc_kind,
  input  logic       exec_as_read,
  input  perm_t      perm,
  output logic       ord_ok
);
  logic bypass;
  assign bypass = lvl_m & ~lock;
  assign ord_ok = (acc_kind != ACC_RSVD) &
                  (bypass | fn_ordinary_ok(acc_kind, perm, exec_as_read));
endmodule

// File: rtl/pmp_entry_perm_check.sv
module pmp_entry_perm_check
  import pmp_perm_pkg::*;
#(
  parameter bit USER_SS_IMPL = 1'b1
) (
  input  logic [1:0] acc_kind,
  input  logic [1:0] priv_lvl,
  input  logic       exec_as_read,
  input  logic       ss_access,
  input  logic       perm_r,
  input  logic       perm_w,
  input  logic       perm_x,
  input  logic       perm_lock,
  input  logic       ext_attr,
  input  logic       m_ss_en,
  input  logic       u_ss_en,
  output logic       permit
);
  perm_t perm;
  logic  lvl_m, lvl_u;
  logic  is_mregion, is_uregion, ext_invalid;
  logic  ss_decided, ss_ok, ord_ok;
  logic  kind_rsvd;

  assign perm      = '{x: perm_x, w: perm_w, r: perm_r};
  assign lvl_m     = (priv_lvl == PRIV_MACHINE);
  assign lvl_u     = (priv_lvl == PRIV_USER);
  assign kind_rsvd = (acc_kind == ACC_RSVD);

  pmp_ss_region_classify #(.USER_SS_IMPL(USER_SS_IMPL)) u_cls (
    .ext_attr    (ext_attr),
    .perm        (perm),
    .m_ss_en     (m_ss_en),
    .u_ss_en     (u_ss_en),
    .is_mregion  (is_mregion),
    .is_uregion  (is_uregion),
    .ext_invalid (ext_invalid)
  );

  pmp_ss_rule #(.USER_SS_IMPL(USER_SS_IMPL)) u_ss (
    .ss_access    (ss_access),
    .lvl_m        (lvl_m),
    .lvl_u        (lvl_u),
    .acc_kind     (acc_kind),
    .exec_as_read (exec_as_read),
    .is_mregion   (is_mregion),
    .is_uregion   (is_uregion),
    .ss_decided   (ss_decided),
    .ss_ok        (ss_ok)
  );

  pmp_ordinary_rule u_ord (
    .lvl_m        (lvl_m),
    .lock         (perm_lock),
    .acc_kind     (acc_kind),
    .exec_as_read (exec_as_read),
    .perm         (perm),
    .ord_ok       (ord_ok)
  );

  always_comb begin
    if (kind_rsvd)        permit = 1'b0;
    else if (ss_decided)  permit = ss_ok;
    else if (ext_invalid) permit = 1'b0;
    else                  permit = ord_ok;
  end
endmodule

// File: rtl/pmp_entry_perm_check_chk.sv
module pmp_entry_perm_check_chk #(
  parameter bit USER_SS_IMPL = 1'b1
) (
  input logic [1:0] acc_kind,
  input logic [1:0] priv_lvl,
  input logic       exec_as_read,
  input logic       ss_access,
  input logic       perm_r,
  input logic       perm_w,
  input logic       perm_x,
  input logic       perm_lock,
  input logic       ext_attr,
  input logic       m_ss_en,
  input logic       u_ss_en,
  input logic       is_mregion,
  input logic       is_uregion,
  input logic       permit
);
  logic unused_in;
  assign unused_in = perm_lock;

  always_comb begin
    // R1
    m_ss_access_chk: assert (!(ss_access && priv_lvl == 2'd3 && acc_kind != 2'd3) ||
                             permit == (ext_attr && m_ss_en && {perm_x, perm_w, perm_r} == 3'b010));
    // R2
    u_ss_access_chk: assert (!(USER_SS_IMPL && ss_access && priv_lvl == 2'd0 && acc_kind != 2'd3) ||
                             permit == (ext_attr && u_ss_en && {perm_x, perm_w, perm_r} == 3'b110));
    // R3
    m_region_load_chk: assert (!(is_mregion && !ss_access && permit) ||
                               (priv_lvl == 2'd3 && acc_kind == 2'd0 && !exec_as_read));
    // R4
    u_region_load_chk: assert (!(is_uregion && !ss_access && permit) ||
                               (priv_lvl == 2'd0 && acc_kind == 2'd0 && !exec_as_read));
    // R5
    ext_deny_chk: assert (!(ext_attr && !is_mregion && !is_uregion) || !permit);
    // R9
    no_user_region_chk: assert (USER_SS_IMPL || !is_uregion);
    // R10
    rsvd_kind_chk: assert (acc_kind != 2'd3 || !permit);
  end
endmodule

bind pmp_entry_perm_check pmp_entry_perm_check_chk #(.USER_SS_IMPL(USER_SS_IMPL)) u_chk (
  .acc_kind     (acc_kind),
  .priv_lvl     (priv_lvl),
  .exec_as_read (exec_as_read),
  .ss_access    (ss_access),
  .perm_r       (perm_r),
  .perm_w       (perm_w),
  .perm_x       (perm_x),
  .perm_lock    (perm_lock),
  .ext_attr     (ext_attr),
  .m_ss_en      (m_ss_en),
  .u_ss_en      (u_ss_en),
  .is_mregion   (is_mregion),
  .is_uregion   (is_uregion),
  .permit       (permit)
);

// File: tb/tb_pmp_entry_perm_check.sv
module tb_pmp_entry_perm_check;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0] acc_kind, priv_lvl;
  logic exec_as_read, ss_access, perm_r, perm_w, perm_x, perm_lock, ext_attr;
  logic m_ss_en, u_ss_en;
  logic permit, permit_nu;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  pmp_entry_perm_check #(.USER_SS_IMPL(1'b1)) dut (
    .acc_kind(acc_kind), .priv_lvl(priv_lvl), .exec_as_read(exec_as_read),
    .ss_access(ss_access), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .perm_lock(perm_lock), .ext_attr(ext_attr), .m_ss_en(m_ss_en),
    .u_ss_en(u_ss_en), .permit(permit));

  pmp_entry_perm_check #(.USER_SS_IMPL(1'b0)) dut_nu (
    .acc_kind(acc_kind), .priv_lvl(priv_lvl), .exec_as_read(exec_as_read),
    .ss_access(ss_access), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .perm_lock(perm_lock), .ext_attr(ext_attr), .m_ss_en(m_ss_en),
    .u_ss_en(u_ss_en), .permit(permit_nu));

  // fields: ss hlvx priv[2] kind[2] ext lock x w r men uen | exp_with_user exp_without_user
  localparam logic [14:0] VEC [18] = '{
    15'b1_0_11_01_1_0_010_1_0_1_1, // R1 M ss store to machine region
    15'b1_0_11_01_1_0_010_0_0_0_0, // R1 machine enable off
    15'b1_0_11_01_1_0_110_0_1_0_0, // R1 M ss to user region
    15'b1_0_00_01_1_0_110_0_1_1_0, // R2 U ss store to user region
    15'b0_0_00_00_1_0_110_0_1_1_0, // R4 U load to user region
    15'b0_1_00_00_1_0_110_0_1_0_0, // R4 execute-as-read load
    15'b0_0_11_00_1_0_010_1_0_1_1, // R3 M load to machine region
    15'b0_0_11_01_1_0_010_1_0_0_0, // R3 M store to machine region
    15'b0_0_00_00_1_0_010_1_0_0_0, // R3 U load to machine region
    15'b0_0_11_00_1_0_111_1_1_0_0, // R5 ext set, rwx
    15'b0_0_11_10_0_0_000_0_0_1_1, // R7 M unlocked fetch
    15'b0_0_11_10_0_1_000_0_0_0_0, // R6 M locked fetch
    15'b0_1_01_00_0_0_001_0_0_0_0, // R6 S exec-as-read without x
    15'b0_1_01_00_0_0_101_0_0_1_1, // R6 S exec-as-read with x
    15'b1_0_01_01_0_0_010_0_0_1_1, // R8 S ss store falls through
    15'b1_0_00_01_0_0_010_0_0_0_1, // R8 U ss store, no user support
    15'b0_0_11_11_0_0_111_0_0_0_0, // R10 reserved kind
    15'b0_0_01_01_0_0_001_0_0_0_0  // R6 S store without w
  };

  function automatic logic ref_permit(input logic [12:0] s, input bit impl);
    logic ss, xr, e, l, x, w, r, me, ue;
    logic [1:0] pv, kd;
    logic m_rg, u_rg, atm, atu;
    {ss, xr, pv, kd, e, l, x, w, r, me, ue} = s;
    atm  = (pv == 2'b11);
    atu  = (pv == 2'b00);
    m_rg = e & me & ~x & w & ~r;
    u_rg = impl & e & ue & x & w & ~r;
    if (kd == 2'b11) return 1'b0;
    if (ss && atm) return m_rg;
    if (ss && atu && impl) return u_rg;
    if (m_rg || u_rg) return (m_rg ? atm : atu) && kd == 2'b00 && !xr;
    if (e) return 1'b0;
    if (atm && !l) return 1'b1;
    return (kd == 2'b00) ? (r && (x || !xr)) : (kd == 2'b01) ? w : x;
  endfunction

  task automatic apply(input logic [12:0] s);
    @(posedge clk);
    {ss_access, exec_as_read, priv_lvl, acc_kind, ext_attr, perm_lock,
     perm_x, perm_w, perm_r, m_ss_en, u_ss_en} = s;
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req, input int idx);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s item %0d: permit=%b expected=%b", req, idx, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    apply(13'd0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state: user load from an empty entry is denied
    check(permit, 1'b0, "R6", -1);
    check(permit_nu, 1'b0, "R6", -1);

    for (int i = 0; i < 18; i++) begin
      apply(VEC[i][14:2]);
      check(permit, VEC[i][1], "R1-table", i);
      check(permit_nu, VEC[i][0], "R9-table", i);
    end

    // R9 user-region encoding without user support denies every access
    apply(13'b0_0_00_00_1_0_110_1_1);
    check(permit_nu, 1'b0, "R9", 0);
    // R2 U ss access to machine region denied with user support
    apply(13'b1_0_00_01_1_0_010_1_1);
    check(permit, 1'b0, "R2", 0);
    // R7 M unlocked store with no permission bits
    apply(13'b0_0_11_01_0_0_000_0_0);
    check(permit, 1'b1, "R7", 0);

    // full sweep against the reference ladder (covers R1 through R10)
    for (int k = 0; k < 8192; k++) begin
      apply(k[12:0]);
      check(permit, ref_permit(k[12:0], 1'b1), "R5-sweep", k);
      check(permit_nu, ref_permit(k[12:0], 1'b0), "R8-sweep", k);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule